// File: doc/BRIEF.md
# Reconciliation Fault Response Controller

This block sits between the MAC-side column interface and the physical column interface of a multi-lane link. Each column carries one byte and one control flag per lane, with lane 0 in the low byte and control bit 0. The block receives a two-bit fault-state code from an upstream qualifier and reshapes both directions to match. All outputs are registered, so every column appears one clock after it enters.

On the transmit side, a state machine has five states:

- `TX_PASS` forwards MAC columns.
- `TX_LF_RF` and `TX_LF_IDLE` alternate the remote-fault column with idle while a local fault is present. MAC data is ignored in both.
- `TX_RF_QUIET` sends idle while a remote fault is present.
- `TX_RESUME` holds idle after a fault clears, until the MAC reaches a frame boundary.

The transitions are:

- Fault entry from `TX_PASS`. If a frame is still open, the block first sends a cut column.
- Local-fault toggling between `TX_LF_RF` and `TX_LF_IDLE`.
- Local to remote: any local-fault state goes to `TX_RF_QUIET`.
- Remote to local: `TX_RF_QUIET` goes to `TX_LF_IDLE` and emits the remote-fault column.
- Fault clear: any fault state goes to `TX_RESUME`.
- Resume: `TX_RESUME` goes to `TX_PASS` on an all-idle MAC column.

On the receive side, the block behaves as follows:

- During any fault, it replaces every column toward the MAC with idle.
- Without a fault, it scrubs received link-signal ordered sets to idle.
- The link status output follows the fault code.

Top module: `rsf_fault_response`

## Requirements
- R1: While reset is asserted, both column outputs carry the idle column (every lane control with 0x07) and `link_up` is low.
- R2: With fault code 00, the MAC transmit column appears unchanged on the PHY transmit output one cycle later.
- R3: With fault code 00, the PHY receive column is forwarded to the MAC one cycle later. The exception is a link-signal ordered set: lane 0 control 0x9C with all other lanes data. That column is replaced by the idle column.
- R4: `link_up` is high one cycle after fault code 00 and low one cycle after any other code.
- R5: With any nonzero fault code, the MAC receive output is the idle column one cycle later.
- R6: Codes 01 and 11 mean local fault. In local fault, transmit output alternates the remote-fault column with idle, starting with the remote-fault column. The remote-fault column is lane 0 control 0x9C, middle lanes data 0x00, and the last lane data 0x02. MAC transmit input is ignored.
- R7: A frame is open once a start column (lane 0 control 0xFB) has been forwarded and no terminate character (control 0xFD) has followed. Entering any fault while a frame is open produces one cut column first: lane 0 control 0xFE, lane 1 control 0xFD, other lanes idle. In local fault, the remote-fault column follows the cut column.
- R8: Code 10 means remote fault. In remote fault, transmit output is idle and MAC transmit input is ignored.
- R9: After the fault code returns to 00, transmit output stays idle until a MAC column that is entirely idle arrives. That column and the ones after it are forwarded.
- R10: A change from local to remote fault sends idle next. A change from remote to local fault sends the remote-fault column next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Column clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_code | input | 2 | 00 none, 01/11 local fault, 10 remote fault |
| mac_txd | input | 8*LANES | MAC transmit column data |
| mac_txc | input | LANES | MAC transmit column control flags |
| phy_txd | output | 8*LANES | Transmit column data toward the PHY |
| phy_txc | output | LANES | Transmit column control flags toward the PHY |
| phy_rxd | input | 8*LANES | Receive column data from the PHY |
| phy_rxc | input | LANES | Receive column control flags from the PHY |
| mac_rxd | output | 8*LANES | Receive column data toward the MAC |
| mac_rxc | output | LANES | Receive column control flags toward the MAC |
| link_up | output | 1 | Link status, high only without a fault |

## Verification
Two functions can land in the same column: closing an open frame with the cut column, and starting fault signalling. The bench provokes this by raising a local fault in the column right after a forwarded start column. It expects the cut column first and the remote-fault column in the following cycle, never both merged or either skipped. The same collision is repeated for remote fault, where idle must follow the cut. A received link-signal ordered set is also placed in the same cycle as a fault clearing, to judge the scrub against the release of the receive path.

// File: rtl/rsf_pkg.sv
package rsf_pkg;

    typedef enum logic [2:0] {
        TX_PASS     = 3'd0,
        TX_LF_RF    = 3'd1,
        TX_LF_IDLE  = 3'd2,
        TX_RF_QUIET = 3'd3,
        TX_RESUME   = 3'd4
    } tx_state_e;

    localparam logic [1:0] FLT_NONE   = 2'b00;
    localparam logic [1:0] FLT_REMOTE = 2'b10;

    localparam logic [7:0] CH_IDLE   = 8'h07;
    localparam logic [7:0] CH_START  = 8'hFB;
    localparam logic [7:0] CH_TERM   = 8'hFD;
    localparam logic [7:0] CH_ERR    = 8'hFE;
    localparam logic [7:0] CH_SIGNAL = 8'h9C;
    localparam logic [7:0] CH_ZERO   = 8'h00;
    localparam logic [7:0] CH_RFCODE = 8'h02;

endpackage

// File: rtl/rsf_col_const.sv
module rsf_col_const
    import rsf_pkg::*;
#(
    parameter int LANES = 4
) (
    output logic [8*LANES-1:0] idle_d,
    output logic [LANES-1:0]   idle_c,
    output logic [8*LANES-1:0] rf_d,
    output logic [LANES-1:0]   rf_c,
    output logic [8*LANES-1:0] cut_d,
    output logic [LANES-1:0]   cut_c
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign idle_d[8*l +: 8] = CH_IDLE;
        assign idle_c[l]        = 1'b1;
        assign cut_c[l]         = 1'b1;

        if (l == 0) begin : g_first
            assign rf_d[8*l +: 8]  = CH_SIGNAL;
            assign rf_c[l]         = 1'b1;
            assign cut_d[8*l +: 8] = CH_ERR;
        end else begin : g_rest
            assign rf_d[8*l +: 8]  = (l == LANES-1) ? CH_RFCODE : CH_ZERO;
            assign rf_c[l]         = 1'b0;
            assign cut_d[8*l +: 8] = (l == 1) ? CH_TERM : CH_IDLE;
        end
    end

endmodule

// File: rtl/rsf_tx_ctrl.sv
module rsf_tx_ctrl
    import rsf_pkg::*;
#(
    parameter int LANES = 4,
    localparam int DW   = 8*LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       fault_code,
    input  logic [DW-1:0]    mac_txd,
    input  logic [LANES-1:0] mac_txc,
    input  logic [DW-1:0]    idle_d,
    input  logic [LANES-1:0] idle_c,
    input  logic [DW-1:0]    rf_d,
    input  logic [LANES-1:0] rf_c,
    input  logic [DW-1:0]    cut_d,
    input  logic [LANES-1:0] cut_c,
    output logic [DW-1:0]    phy_txd,
    output logic [LANES-1:0] phy_txc
);

    tx_state_e        state_q, state_d;
    logic             open_q, open_d;
    logic [DW-1:0]    out_d;
    logic [LANES-1:0] out_c;

    logic is_local, is_remote;
    logic mac_start, mac_term, mac_all_idle;

    assign is_local  = fault_code[0];
    assign is_remote = (fault_code == FLT_REMOTE);
    assign mac_start = mac_txc[0] && (mac_txd[7:0] == CH_START);

    always_comb begin
        mac_term     = 1'b0;
        mac_all_idle = 1'b1;
        for (int l = 0; l < LANES; l++) begin
            if (mac_txc[l] && mac_txd[8*l +: 8] == CH_TERM) mac_term = 1'b1;
            if (!mac_txc[l] || mac_txd[8*l +: 8] != CH_IDLE) mac_all_idle = 1'b0;
        end
    end

    // next state and next column
    always_comb begin
        state_d = state_q;
        out_d   = idle_d;
        out_c   = idle_c;
        unique case (state_q)
            TX_PASS: begin
                if (is_local) begin
                    out_d   = open_q ? cut_d : rf_d;
                    out_c   = open_q ? cut_c : rf_c;
                    state_d = open_q ? TX_LF_RF : TX_LF_IDLE;
                end else if (is_remote) begin
                    out_d   = open_q ? cut_d : idle_d;
                    out_c   = open_q ? cut_c : idle_c;
                    state_d = TX_RF_QUIET;
                end else begin
                    out_d = mac_txd;
                    out_c = mac_txc;
                end
            end
            TX_LF_RF: begin
                if (is_local) begin
                    out_d   = rf_d;
                    out_c   = rf_c;
                    state_d = TX_LF_IDLE;
                end else if (is_remote) begin
                    state_d = TX_RF_QUIET;
                end else begin
                    state_d = TX_RESUME;
                end
            end
            TX_LF_IDLE: begin
                if (is_local)       state_d = TX_LF_RF;
                else if (is_remote) state_d = TX_RF_QUIET;
                else                state_d = TX_RESUME;
            end
            TX_RF_QUIET: begin
                if (is_local) begin
                    out_d   = rf_d;
                    out_c   = rf_c;
                    state_d = TX_LF_IDLE;
                end else if (!is_remote) begin
                    state_d = TX_RESUME;
                end
            end
            TX_RESUME: begin
                if (is_local) begin
                    out_d   = rf_d;
                    out_c   = rf_c;
                    state_d = TX_LF_IDLE;
                end else if (is_remote) begin
                    state_d = TX_RF_QUIET;
                end else if (mac_all_idle) begin
                    out_d   = mac_txd;
                    out_c   = mac_txc;
                    state_d = TX_PASS;
                end
            end
            default: state_d = TX_PASS;
        endcase
    end

    always_comb begin
        if (state_q == TX_PASS && state_d == TX_PASS)
            open_d = mac_start ? !mac_term : (open_q && !mac_term);
        else
            open_d = 1'b0;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_PASS;
            open_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            open_q  <= open_d;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phy_txd <= {LANES{CH_IDLE}};
            phy_txc <= '1;
        end else begin
            phy_txd <= out_d;
            phy_txc <= out_c;
        end
    end

endmodule

// File: rtl/rsf_rx_gate.sv
module rsf_rx_gate
    import rsf_pkg::*;
#(
    parameter int LANES = 4,
    localparam int DW   = 8*LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       fault_code,
    input  logic [DW-1:0]    phy_rxd,
    input  logic [LANES-1:0] phy_rxc,
    input  logic [DW-1:0]    idle_d,
    input  logic [LANES-1:0] idle_c,
    output logic [DW-1:0]    mac_rxd,
    output logic [LANES-1:0] mac_rxc,
    output logic             link_up
);

    logic link_sig, no_fault;

    assign no_fault = (fault_code == FLT_NONE);
    assign link_sig = (phy_rxc == LANES'(1)) && (phy_rxd[7:0] == CH_SIGNAL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mac_rxd <= {LANES{CH_IDLE}};
            mac_rxc <= '1;
            link_up <= 1'b0;
        end else begin
            link_up <= no_fault;
            if (!no_fault || link_sig) begin
                mac_rxd <= idle_d;
                mac_rxc <= idle_c;
            end else begin
                mac_rxd <= phy_rxd;
                mac_rxc <= phy_rxc;
            end
        end
    end

endmodule

// File: rtl/rsf_fault_response.sv
module rsf_fault_response
    import rsf_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           fault_code,
    input  logic [8*LANES-1:0]   mac_txd,
    input  logic [LANES-1:0]     mac_txc,
    output logic [8*LANES-1:0]   phy_txd,
    output logic [LANES-1:0]     phy_txc,
    input  logic [8*LANES-1:0]   phy_rxd,
    input  logic [LANES-1:0]     phy_rxc,
    output logic [8*LANES-1:0]   mac_rxd,
    output logic [LANES-1:0]     mac_rxc,
    output logic                 link_up
);

    localparam int DW = 8*LANES;

    logic [DW-1:0]    idle_d, rf_d, cut_d;
    logic [LANES-1:0] idle_c, rf_c, cut_c;

    rsf_col_const #(.LANES(LANES)) u_const (
        .idle_d(idle_d), .idle_c(idle_c),
        .rf_d(rf_d),     .rf_c(rf_c),
        .cut_d(cut_d),   .cut_c(cut_c)
    );

    rsf_tx_ctrl #(.LANES(LANES)) u_tx (
        .clk(clk), .rst_n(rst_n), .fault_code(fault_code),
        .mac_txd(mac_txd), .mac_txc(mac_txc),
        .idle_d(idle_d), .idle_c(idle_c),
        .rf_d(rf_d), .rf_c(rf_c),
        .cut_d(cut_d), .cut_c(cut_c),
        .phy_txd(phy_txd), .phy_txc(phy_txc)
    );

    rsf_rx_gate #(.LANES(LANES)) u_rx (
        .clk(clk), .rst_n(rst_n), .fault_code(fault_code),
        .phy_rxd(phy_rxd), .phy_rxc(phy_rxc),
        .idle_d(idle_d), .idle_c(idle_c),
        .mac_rxd(mac_rxd), .mac_rxc(mac_rxc),
        .link_up(link_up)
    );

endmodule

// File: rtl/rsf_fault_response_chk.sv
module rsf_fault_response_chk #(
    parameter int LANES = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [1:0]           fault_code,
    input logic [8*LANES-1:0]   phy_txd,
    input logic [LANES-1:0]     phy_txc,
    input logic [8*LANES-1:0]   mac_rxd,
    input logic [LANES-1:0]     mac_rxc,
    input logic                 link_up
);

    function automatic logic [8*LANES-1:0] rf_pattern();
        logic [8*LANES-1:0] v;
        for (int l = 0; l < LANES; l++)
            v[8*l +: 8] = (l == 0) ? 8'h9C : ((l == LANES-1) ? 8'h02 : 8'h00);
        return v;
    endfunction

    localparam logic [8*LANES-1:0] RF_D = rf_pattern();
    localparam logic [8*LANES-1:0] IDLE_D = {LANES{8'h07}};

    logic past_ok;
    logic tx_sig;
    logic rx_idle;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assign tx_sig  = (phy_txc == LANES'(1)) && (phy_txd == RF_D);
    assign rx_idle = (mac_rxc == '1) && (mac_rxd == IDLE_D);

    assert_link_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (link_up == ($past(fault_code) == 2'b00)));

    assert_rx_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(fault_code) != 2'b00) |-> rx_idle);

    assert_rf_only_local_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && tx_sig) |-> $past(fault_code[0]));

    assert_rf_alternates_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_sig |=> !tx_sig);

    assert_no_signal_to_mac_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(mac_rxc[0] && mac_rxd[7:0] == 8'h9C));

endmodule

bind rsf_fault_response rsf_fault_response_chk #(.LANES(LANES)) u_chk (
    .clk(clk), .rst_n(rst_n), .fault_code(fault_code),
    .phy_txd(phy_txd), .phy_txc(phy_txc),
    .mac_rxd(mac_rxd), .mac_rxc(mac_rxc), .link_up(link_up)
);

// File: tb/test_rsf_fault_response.sv
module test_rsf_fault_response;

    localparam int PERIOD = 10;

    localparam logic [31:0] IDLE_D  = 32'h07070707;
    localparam logic [3:0]  IDLE_C  = 4'hF;
    localparam logic [31:0] RF_D    = 32'h0200009C;
    localparam logic [3:0]  RF_C    = 4'h1;
    localparam logic [31:0] CUT_D   = 32'h0707FDFE;
    localparam logic [3:0]  CUT_C   = 4'hF;
    localparam logic [31:0] START_D = 32'h555555FB;
    localparam logic [3:0]  START_C = 4'h1;
    localparam logic [31:0] DATA_D  = 32'hA1B2C3D4;
    localparam logic [3:0]  DATA_C  = 4'h0;
    localparam logic [31:0] TERM_D  = 32'h070707FD;
    localparam logic [3:0]  TERM_C  = 4'hF;
    localparam logic [31:0] OS_D    = 32'h0100009C;
    localparam logic [3:0]  OS_C    = 4'h1;
    localparam logic [31:0] RXA_D   = 32'h11223344;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  fault_code = 2'b00;
    logic [31:0] mac_txd = IDLE_D, phy_rxd = IDLE_D;
    logic [3:0]  mac_txc = IDLE_C, phy_rxc = IDLE_C;
    logic [31:0] phy_txd, mac_rxd;
    logic [3:0]  phy_txc, mac_rxc;
    logic        link_up;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] txd;
        logic [3:0]  txc;
        logic [31:0] rxd;
        logic [3:0]  rxc;
        logic        link;
        string       req;
    } exp_t;

    exp_t exp_q[$];

    always #(PERIOD/2) clk = ~clk;

    rsf_fault_response #(.LANES(4)) i_rsf_fault_response (
        .clk(clk), .rst_n(rst_n), .fault_code(fault_code),
        .mac_txd(mac_txd), .mac_txc(mac_txc),
        .phy_txd(phy_txd), .phy_txc(phy_txc),
        .phy_rxd(phy_rxd), .phy_rxc(phy_rxc),
        .mac_rxd(mac_rxd), .mac_rxc(mac_rxc),
        .link_up(link_up)
    );

    task automatic step(input logic [1:0] f,
                        input logic [31:0] mtd, input logic [3:0] mtc,
                        input logic [31:0] prd, input logic [3:0] prc,
                        input logic [31:0] etd, input logic [3:0] etc_,
                        input logic [31:0] erd, input logic [3:0] erc,
                        input logic el, input string req);
        exp_t e;
        @(negedge clk);
        fault_code = f;
        mac_txd = mtd; mac_txc = mtc;
        phy_rxd = prd; phy_rxc = prc;
        e.txd = etd; e.txc = etc_; e.rxd = erd; e.rxc = erc; e.link = el; e.req = req;
        exp_q.push_back(e);
    endtask

    // monitor: compares one cycle after each driven column
    initial begin
        forever begin
            @(posedge clk);
            #(PERIOD/4);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                total++;
                if (phy_txd !== e.txd || phy_txc !== e.txc || mac_rxd !== e.rxd ||
                    mac_rxc !== e.rxc || link_up !== e.link) begin
                    bad++;
                    $display("FAIL %s: got tx=%h/%h rx=%h/%h link=%b exp tx=%h/%h rx=%h/%h link=%b",
                             e.req, phy_txd, phy_txc, mac_rxd, mac_rxc, link_up,
                             e.txd, e.txc, e.rxd, e.rxc, e.link);
                end
            end
        end
    end

    initial begin
        #(PERIOD*5000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got hung run, exp completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #(PERIOD/4);
        total++;
        if (phy_txd !== IDLE_D || phy_txc !== IDLE_C || mac_rxd !== IDLE_D ||
            mac_rxc !== IDLE_C || link_up !== 1'b0) begin
            bad++;
            $display("FAIL R1: got tx=%h/%h rx=%h/%h link=%b exp idle and link 0",
                     phy_txd, phy_txc, mac_rxd, mac_rxc, link_up);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R2 R3 R4: pass-through without fault
        step(2'b00, IDLE_D, IDLE_C, IDLE_D, IDLE_C, IDLE_D, IDLE_C, IDLE_D, IDLE_C, 1, "R2");
        step(2'b00, START_D, START_C, RXA_D, DATA_C, START_D, START_C, RXA_D, DATA_C, 1, "R2");
        step(2'b00, DATA_D, DATA_C, OS_D, OS_C, DATA_D, DATA_C, IDLE_D, IDLE_C, 1, "R3");
        step(2'b00, TERM_D, TERM_C, START_D, START_C, TERM_D, TERM_C, START_D, START_C, 1, "R2");
        // R6 R5 R4: local fault outside a frame
        step(2'b01, DATA_D, DATA_C, RXA_D, DATA_C, RF_D, RF_C, IDLE_D, IDLE_C, 0, "R6");
        step(2'b01, START_D, START_C, RXA_D, DATA_C, IDLE_D, IDLE_C, IDLE_D, IDLE_C, 0, "R6");
        step(2'b01, DATA_D, DATA_C, OS_D, OS_C, RF_D, RF_C, IDLE_D, IDLE_C, 0, "R5");
        step(2'b01, DATA_D, DATA_C, RXA_D, DATA_C, IDLE_D, IDLE_C, IDLE_D, IDLE_C, 0, "R6");
        // R9: fault clears while MAC is mid-frame
        step(2'b00, DATA_D, DATA_C, RXA_D, DATA_C, IDLE_D, IDLE_C, RXA_D, DATA_C, 1, "R9");
        step(2'b00, TERM_D, TERM_C, RXA_D, DATA_C, IDLE_D, IDLE_C, RXA_D, DATA_C, 1, "R9");
        step(2'b00, IDLE_D, IDLE_C, IDLE_D, IDLE_C, IDLE_D, IDLE_C, IDLE_D, IDLE_C, 1, "R9");
        step(2'b00, START_D, START_C, RXA_D, DATA_C, START_D, START_C, RXA_D, DATA_C, 1, "R9");
        // R7: local fault cuts an open frame
        step(2'b01, DATA_D, DATA_C, RXA_D, DATA_C, CUT_D, CUT_C, IDLE_D, IDLE_C, 0, "R7");
        step(2'b01, DATA_D, DATA_C, RXA_D, DATA_C, RF_D, RF_C, IDLE_D, IDLE_C, 0, "R7");
        step(2'b01, DATA_D, DATA_C, RXA_D, DATA_C, IDLE_D, IDLE_C, IDLE_D, IDLE_C, 0, "R6");
        // R10 R8: local to remote and back
        step(2'b10, DATA_D, DATA_C, RXA_D, DATA_C, IDLE_D, IDLE_C, IDLE_D, IDLE_C, 0, "R10");
        step(2'b10, START_D, START_C, RXA_D, DATA_C, IDLE_D, IDLE_C, IDLE_D, IDLE_C, 0, "R8");
        step(2'b01, DATA_D, DATA_C, RXA_D, DATA_C, RF_D, RF_C, IDLE_D, IDLE_C, 0, "R10");
        // R6: code 11 acts as local fault
        step(2'b11, DATA_D, DATA_C, RXA_D, DATA_C, IDLE_D, IDLE_C, IDLE_D, IDLE_C, 0, "R6");
        step(2'b11, DATA_D, DATA_C, RXA_D, DATA_C, RF_D, RF_C, IDLE_D, IDLE_C, 0, "R6");
        // fault clears in the same cycle a link-signal set arrives
        step(2'b00, IDLE_D, IDLE_C, OS_D, OS_C, IDLE_D, IDLE_C, IDLE_D, IDLE_C, 1, "R3");
        step(2'b00, IDLE_D, IDLE_C, RXA_D, DATA_C, IDLE_D, IDLE_C, RXA_D, DATA_C, 1, "R9");
        step(2'b00, START_D, START_C, RXA_D, DATA_C, START_D, START_C, RXA_D, DATA_C, 1, "R2");
        // R7 R8: remote fault cuts an open frame
        step(2'b10, DATA_D, DATA_C, RXA_D, DATA_C, CUT_D, CUT_C, IDLE_D, IDLE_C, 0, "R7");
        step(2'b10, DATA_D, DATA_C, RXA_D, DATA_C, IDLE_D, IDLE_C, IDLE_D, IDLE_C, 0, "R8");
        step(2'b00, IDLE_D, IDLE_C, RXA_D, DATA_C, IDLE_D, IDLE_C, RXA_D, DATA_C, 1, "R9");
        step(2'b00, IDLE_D, IDLE_C, IDLE_D, IDLE_C, IDLE_D, IDLE_C, IDLE_D, IDLE_C, 1, "R9");
        step(2'b00, DATA_D, DATA_C, OS_D, OS_C, DATA_D, DATA_C, IDLE_D, IDLE_C, 1, "R2");

        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule